// File: doc/BRIEF.md
# Remote-Terminal Mailbox Address Generator

This block turns an accepted command word into a sequence of local memory addresses, one per data word of the message, for a serial-bus remote terminal. The address is assembled from the command's broadcast flag, transmit/receive bit, 5-bit subaddress and a 5-bit word position. Every transmit/receive and subaddress pair therefore owns its own 32-word mailbox in a 4K-word space. A word counter fills the low field and advances each time the transfer logic reports a completed word.

Commands arrive on a valid/ready stream. The generator takes a command only when no message is in progress. A source that sees `cmd_ready` low must hold `cmd_valid` and the command fields steady until the command is taken. Mode commands sent to subaddress 0 or 31 are handled differently:
- Commands that carry one data word in memory are placed at an offset equal to their mode code.
- Transmit-last-command and transmit-BIT-word take their data word from an internal register, which a select output names.
- Mode codes without a data word finish with no access at all.

Top module: `mbx_addr_gen`

## Requirements
- R1: While a data word is being addressed, address bit 11 equals the accepted broadcast flag and bit 10 the accepted transmit/receive bit.
- R2: Address bits 9..5 equal the accepted subaddress, and bits 4..0 hold the position of the word inside the 32-word mailbox.
- R3: For a subaddress other than 0 and 31, the cycle after acceptance shows `mem_sel` high with position 0. Each cycle with `word_done` high advances the position by one in the next cycle. Without `word_done`, the address holds.
- R4: A word count of n (1..31) yields n word addresses and a count of 0 yields 32. One cycle after the `word_done` of the last word, `mem_sel` is low and `msg_done` is high for that cycle.
- R5: At subaddress 0 or 31, mode codes 16, 17, 20 and 21 yield exactly one word, with `mem_sel` high and position equal to the mode code.
- R6: At subaddress 0 or 31, mode code 18 yields one word with `reg_last_sel` high, and mode code 19 yields one word with `reg_bit_sel` high; `mem_sel` stays low for both.
- R7: At subaddress 0 or 31, any other mode code gives no word: all selects stay low, and `msg_done` is high in the cycle after acceptance.
- R8: `cmd_ready` is high exactly when no message is active. A command is taken on a clock edge with `cmd_valid` and `cmd_ready` both high. A command held while the generator is busy is taken on the edge that ends the current message. `word_done` while idle changes nothing.
- R9: After reset, `cmd_ready` is high and `mem_sel`, `reg_last_sel`, `reg_bit_sel` and `msg_done` are low.
- R10: At most one of `mem_sel`, `reg_last_sel` and `reg_bit_sel` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command fields are offered |
| cmd_ready | output | 1 | Generator idle and able to take a command |
| cmd_bcast | input | 1 | Broadcast flag of the command |
| cmd_tx | input | 1 | Transmit/receive bit of the command |
| cmd_subaddr | input | 5 | Subaddress or mode indicator |
| cmd_count | input | 5 | Word count, or mode code at subaddress 0/31 |
| word_done | input | 1 | Current word has been transferred |
| addr | output | 12 | Mailbox address of the current word |
| mem_sel | output | 1 | Current word lives in memory |
| reg_last_sel | output | 1 | Current word is the last-command register |
| reg_bit_sel | output | 1 | Current word is the built-in-test register |
| msg_done | output | 1 | One-cycle pulse when the message is finished |

## Verification
The properties assume the following about the inputs:
- `word_done` is raised only for a word that the generator is presenting.
- A command offered while `cmd_ready` is low stays unchanged until it is taken.

Under those assumptions, an address step can be checked against the previous cycle alone. The stimulus raises `word_done` only after a command has been taken. One test also raises `word_done` while the generator is idle, since R8 says it must be ignored there. In the back-pressure test, the waiting command is held with fixed fields across the whole remainder of the current message.

// File: rtl/mbx_pkg.sv
`timescale 1ns/1ps
package mbx_pkg;
  localparam int MC_W = 5;

  localparam logic [MC_W-1:0] MC_TX_VECTOR  = 5'd16;
  localparam logic [MC_W-1:0] MC_SYNC_DATA  = 5'd17;
  localparam logic [MC_W-1:0] MC_TX_LASTCMD = 5'd18;
  localparam logic [MC_W-1:0] MC_TX_BITWORD = 5'd19;
  localparam logic [MC_W-1:0] MC_SEL_SHDN   = 5'd20;
  localparam logic [MC_W-1:0] MC_OVR_SHDN   = 5'd21;

  typedef enum logic [1:0] {
    KIND_DATA     = 2'd0,
    KIND_MODE_MEM = 2'd1,
    KIND_MODE_REG = 2'd2,
    KIND_MODE_NIL = 2'd3
  } msg_kind_e;
endpackage

// File: rtl/mbx_cmd_classify.sv
`timescale 1ns/1ps
module mbx_cmd_classify #(
  parameter int SA_W = 5,
  parameter int WC_W = 5,
  localparam int CNT_W = WC_W + 1
) (
  input  logic [SA_W-1:0]   subaddr,
  input  logic [WC_W-1:0]   count,
  output mbx_pkg::msg_kind_e kind,
  output logic [WC_W-1:0]   start_pos,
  output logic [CNT_W-1:0]  total,
  output logic              reg_is_bit
);
  import mbx_pkg::*;

  logic is_mode;
  assign is_mode = (subaddr == '0) || (subaddr == '1);

  always_comb begin
    kind       = KIND_DATA;
    start_pos  = '0;
    total      = {1'b0, count};
    reg_is_bit = 1'b0;
    if (is_mode) begin
      start_pos = count;
      if (count == WC_W'(MC_TX_VECTOR) || count == WC_W'(MC_SYNC_DATA) ||
          count == WC_W'(MC_SEL_SHDN)  || count == WC_W'(MC_OVR_SHDN)) begin
        kind  = KIND_MODE_MEM;
        total = CNT_W'(1);
      end else if (count == WC_W'(MC_TX_LASTCMD) || count == WC_W'(MC_TX_BITWORD)) begin
        kind       = KIND_MODE_REG;
        total      = CNT_W'(1);
        reg_is_bit = (count == WC_W'(MC_TX_BITWORD));
      end else begin
        kind  = KIND_MODE_NIL;
        total = '0;
      end
    end else if (count == '0) begin
      total = {1'b1, {WC_W{1'b0}}};
    end
  end
endmodule

// File: rtl/mbx_word_counter.sv
`timescale 1ns/1ps
module mbx_word_counter #(
  parameter int WC_W = 5,
  localparam int CNT_W = WC_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [WC_W-1:0]  load_pos,
  input  logic [CNT_W-1:0] load_total,
  input  logic             step,
  output logic [WC_W-1:0]  pos,
  output logic             active,
  output logic             finish
);
  logic [CNT_W-1:0] left_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos    <= '0;
      left_q <= '0;
      active <= 1'b0;
      finish <= 1'b0;
    end else begin
      finish <= 1'b0;
      if (load) begin
        pos    <= load_pos;
        left_q <= load_total;
        active <= (load_total != '0);
        finish <= (load_total == '0);
      end else if (step && active) begin
        if (left_q == CNT_W'(1)) begin
          active <= 1'b0;
          finish <= 1'b1;
          left_q <= '0;
        end else begin
          pos    <= pos + 1'b1;
          left_q <= left_q - 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/mbx_addr_gen.sv
`timescale 1ns/1ps
module mbx_addr_gen #(
  parameter int SA_W = 5,
  parameter int WC_W = 5,
  localparam int ADDR_W = 2 + SA_W + WC_W,
  localparam int HI_W   = ADDR_W - WC_W,
  localparam int CNT_W  = WC_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic              cmd_bcast,
  input  logic              cmd_tx,
  input  logic [SA_W-1:0]   cmd_subaddr,
  input  logic [WC_W-1:0]   cmd_count,
  input  logic              word_done,
  output logic [ADDR_W-1:0] addr,
  output logic              mem_sel,
  output logic              reg_last_sel,
  output logic              reg_bit_sel,
  output logic              msg_done
);
  import mbx_pkg::*;

  msg_kind_e        cls_kind;
  logic [WC_W-1:0]  cls_start;
  logic [CNT_W-1:0] cls_total;
  logic             cls_is_bit;

  mbx_cmd_classify #(.SA_W(SA_W), .WC_W(WC_W)) u_classify (
    .subaddr    (cmd_subaddr),
    .count      (cmd_count),
    .kind       (cls_kind),
    .start_pos  (cls_start),
    .total      (cls_total),
    .reg_is_bit (cls_is_bit)
  );

  logic            accept;
  logic            active;
  logic [WC_W-1:0] pos;

  assign accept = cmd_valid && cmd_ready;

  mbx_word_counter #(.WC_W(WC_W)) u_counter (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (accept),
    .load_pos   (cls_start),
    .load_total (cls_total),
    .step       (word_done),
    .pos        (pos),
    .active     (active),
    .finish     (msg_done)
  );

  logic [HI_W-1:0] base_q;
  msg_kind_e       kind_q;
  logic            is_bit_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q   <= '0;
      kind_q   <= KIND_MODE_NIL;
      is_bit_q <= 1'b0;
    end else if (accept) begin
      base_q   <= {cmd_bcast, cmd_tx, cmd_subaddr};
      kind_q   <= cls_kind;
      is_bit_q <= cls_is_bit;
    end
  end

  assign cmd_ready    = !active;
  assign addr         = {base_q, pos};
  assign mem_sel      = active && (kind_q == KIND_DATA || kind_q == KIND_MODE_MEM);
  assign reg_last_sel = active && (kind_q == KIND_MODE_REG) && !is_bit_q;
  assign reg_bit_sel  = active && (kind_q == KIND_MODE_REG) && is_bit_q;
endmodule

// File: rtl/mbx_addr_gen_chk.sv
`timescale 1ns/1ps
module mbx_addr_gen_chk #(
  parameter int SA_W = 5,
  parameter int WC_W = 5,
  localparam int ADDR_W = 2 + SA_W + WC_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic              cmd_bcast,
  input logic              cmd_tx,
  input logic [SA_W-1:0]   cmd_subaddr,
  input logic [WC_W-1:0]   cmd_count,
  input logic              word_done,
  input logic [ADDR_W-1:0] addr,
  input logic              mem_sel,
  input logic              reg_last_sel,
  input logic              reg_bit_sel,
  input logic              msg_done
);
  logic acc, is_mode, mc_mem, mc_reg;
  assign acc     = cmd_valid && cmd_ready;
  assign is_mode = (cmd_subaddr == '0) || (cmd_subaddr == '1);
  assign mc_mem  = (cmd_count == WC_W'(16)) || (cmd_count == WC_W'(17)) ||
                   (cmd_count == WC_W'(20)) || (cmd_count == WC_W'(21));
  assign mc_reg  = (cmd_count == WC_W'(18)) || (cmd_count == WC_W'(19));

  // R1, R2, R3: first data word address
  p_data_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
    acc && !is_mode |=> mem_sel &&
      addr == {$past(cmd_bcast), $past(cmd_tx), $past(cmd_subaddr), {WC_W{1'b0}}});

  p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_sel && word_done |=> !mem_sel ||
      (addr[WC_W-1:0] == $past(addr[WC_W-1:0]) + 1'b1 &&
       addr[ADDR_W-1:WC_W] == $past(addr[ADDR_W-1:WC_W])));

  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_sel && !word_done |=> mem_sel && $stable(addr));

  p_done_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    msg_done |-> !mem_sel && !reg_last_sel && !reg_bit_sel && cmd_ready);

  p_mode_mem_r5: assert property (@(posedge clk) disable iff (!rst_n)
    acc && is_mode && mc_mem |=> mem_sel && addr[WC_W-1:0] == $past(cmd_count));

  p_mode_reg_r6: assert property (@(posedge clk) disable iff (!rst_n)
    acc && is_mode && mc_reg |=> !mem_sel && (reg_last_sel || reg_bit_sel));

  p_nodata_r7: assert property (@(posedge clk) disable iff (!rst_n)
    acc && is_mode && !mc_mem && !mc_reg |=>
      msg_done && !mem_sel && !reg_last_sel && !reg_bit_sel);

  p_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_sel || reg_last_sel || reg_bit_sel) |-> !cmd_ready);

  p_onehot_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mem_sel, reg_last_sel, reg_bit_sel}));
endmodule

bind mbx_addr_gen mbx_addr_gen_chk #(.SA_W(SA_W), .WC_W(WC_W)) u_chk (.*);

// File: tb/mbx_addr_gen_test.sv
`timescale 1ns/1ps
module mbx_addr_gen_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic        cmd_bcast = 1'b0;
  logic        cmd_tx = 1'b0;
  logic [4:0]  cmd_subaddr = '0;
  logic [4:0]  cmd_count = '0;
  logic        word_done = 1'b0;
  logic [11:0] addr;
  logic        mem_sel, reg_last_sel, reg_bit_sel, msg_done;

  always #2 clk = ~clk;

  mbx_addr_gen uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_bcast(cmd_bcast), .cmd_tx(cmd_tx), .cmd_subaddr(cmd_subaddr),
    .cmd_count(cmd_count), .word_done(word_done), .addr(addr),
    .mem_sel(mem_sel), .reg_last_sel(reg_last_sel), .reg_bit_sel(reg_bit_sel),
    .msg_done(msg_done)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  // item: [19:16] requirement, [15:14] kind (0 mem, 1 last reg, 2 bit reg, 3 done), [11:0] addr
  logic [19:0] exp_q[$];

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [19:0] item(input int req, input int kind, input logic [11:0] a);
    return {4'(req), 2'(kind), 2'b00, a};
  endfunction

  // expected items from requirements R3..R7; returns word count
  task automatic push_exp(input bit b, input bit t, input logic [4:0] sa,
                          input logic [4:0] c, output int n);
    n = 0;
    if (sa == 5'd0 || sa == 5'd31) begin
      if (c == 5'd16 || c == 5'd17 || c == 5'd20 || c == 5'd21) begin
        exp_q.push_back(item(5, 0, {b, t, sa, c}));           // R5
        n = 1;
        exp_q.push_back(item(5, 3, 12'd0));
      end else if (c == 5'd18 || c == 5'd19) begin
        exp_q.push_back(item(6, (c == 5'd18) ? 1 : 2, 12'd0)); // R6
        n = 1;
        exp_q.push_back(item(6, 3, 12'd0));
      end else begin
        exp_q.push_back(item(7, 3, 12'd0));                   // R7
      end
    end else begin
      n = (c == 5'd0) ? 32 : int'(c);                         // R4
      for (int i = 0; i < n; i++)
        exp_q.push_back(item(3, 0, {b, t, sa, 5'(i)}));       // R1 R2 R3
      exp_q.push_back(item(4, 3, 12'd0));
    end
  endtask

  task automatic offer(input bit b, input bit t, input logic [4:0] sa, input logic [4:0] c);
    cmd_bcast = b; cmd_tx = t; cmd_subaddr = sa; cmd_count = c;
    cmd_valid = 1'b1;
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    @(posedge clk); #1;
    cmd_valid = 1'b0;
  endtask

  task automatic words(input int n, input bit gaps);
    for (int i = 0; i < n; i++) begin
      word_done = 1'b1;
      @(posedge clk); #1;
      word_done = 1'b0;
      if (gaps && (i % 3 == 1)) begin
        @(posedge clk); #1;
      end
    end
  endtask

  task automatic run_msg(input bit b, input bit t, input logic [4:0] sa,
                         input logic [4:0] c, input bit gaps);
    int n;
    push_exp(b, t, sa, c, n);
    offer(b, t, sa, c);
    words(n, gaps);
    @(posedge clk); #1;
  endtask

  // monitor: compares outputs against the scoreboard queue
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      if (word_done && (mem_sel || reg_last_sel || reg_bit_sel)) begin
        int k;
        k = mem_sel ? 0 : (reg_last_sel ? 1 : 2);
        if (exp_q.size() == 0) begin
          check(1'b0, "R8 unexpected word", k, 99);
        end else begin
          logic [19:0] e;
          e = exp_q.pop_front();
          check(k == int'(e[15:14]), $sformatf("R%0d kind", e[19:16]), k, int'(e[15:14]));
          if (k == 0)
            check(addr == e[11:0], $sformatf("R%0d addr R1 R2", e[19:16]), addr, e[11:0]);
        end
      end
      if (msg_done) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R8 unexpected msg_done", 1, 0);
        end else begin
          logic [19:0] e;
          e = exp_q.pop_front();
          check(e[15:14] == 2'd3, $sformatf("R%0d done", e[19:16]), 3, int'(e[15:14]));
          check(!mem_sel && !reg_last_sel && !reg_bit_sel, "R4 selects low at done",
                {mem_sel, reg_last_sel, reg_bit_sel}, 0);
        end
      end
      check(!(mem_sel && reg_last_sel) && !(mem_sel && reg_bit_sel) &&
            !(reg_last_sel && reg_bit_sel), "R10 one select",
            {mem_sel, reg_last_sel, reg_bit_sel}, 0);
    end
  end

  initial begin
    #(4 * 150000);
    if (!finished) begin
      finished = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int n;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R9 reset state
    check(cmd_ready == 1'b1, "R9 ready", cmd_ready, 1);
    check(mem_sel == 1'b0, "R9 mem_sel", mem_sel, 0);
    check(reg_last_sel == 1'b0, "R9 reg_last_sel", reg_last_sel, 0);
    check(reg_bit_sel == 1'b0, "R9 reg_bit_sel", reg_bit_sel, 0);
    check(msg_done == 1'b0, "R9 msg_done", msg_done, 0);
    @(posedge clk); #1;

    // R1 R2 R3 R4 data messages
    run_msg(1'b0, 1'b0, 5'd3, 5'd4, 1'b1);
    run_msg(1'b1, 1'b1, 5'd30, 5'd0, 1'b0);   // 32 words
    run_msg(1'b1, 1'b0, 5'd1, 5'd1, 1'b0);
    run_msg(1'b0, 1'b1, 5'd22, 5'd31, 1'b1);

    // R5 single-word mode commands in memory
    run_msg(1'b0, 1'b1, 5'd0, 5'd17, 1'b0);
    run_msg(1'b1, 1'b1, 5'd31, 5'd16, 1'b0);
    run_msg(1'b0, 1'b0, 5'd31, 5'd20, 1'b0);
    run_msg(1'b0, 1'b0, 5'd0, 5'd21, 1'b0);

    // R6 internal register words
    run_msg(1'b0, 1'b1, 5'd31, 5'd18, 1'b0);
    run_msg(1'b0, 1'b1, 5'd0, 5'd19, 1'b0);

    // R7 mode codes without data
    run_msg(1'b0, 1'b1, 5'd0, 5'd2, 1'b0);
    run_msg(1'b1, 1'b0, 5'd31, 5'd31, 1'b0);
    run_msg(1'b0, 1'b0, 5'd0, 5'd0, 1'b0);

    // R8 word_done while idle is ignored
    repeat (3) begin
      word_done = 1'b1; @(posedge clk); #1;
    end
    word_done = 1'b0;
    @(negedge clk);
    check(cmd_ready && !mem_sel && !msg_done, "R8 idle word_done ignored",
          {cmd_ready, mem_sel, msg_done}, 3'b100);
    @(posedge clk); #1;
    run_msg(1'b0, 1'b0, 5'd5, 5'd2, 1'b0);

    // R8 back-pressure: second command held until first ends
    push_exp(1'b1, 1'b0, 5'd7, 5'd3, n);
    push_exp(1'b0, 1'b1, 5'd8, 5'd2, n);
    offer(1'b1, 1'b0, 5'd7, 5'd3);
    words(1, 1'b0);
    cmd_bcast = 1'b0; cmd_tx = 1'b1; cmd_subaddr = 5'd8; cmd_count = 5'd2;
    cmd_valid = 1'b1;
    @(negedge clk);
    check(cmd_ready == 1'b0, "R8 busy not ready", cmd_ready, 0);
    @(posedge clk); #1;
    words(2, 1'b0);
    @(negedge clk);
    check(cmd_ready == 1'b1 && msg_done == 1'b1, "R8 ready at end R4",
          {cmd_ready, msg_done}, 2'b11);
    @(posedge clk); #1;
    cmd_valid = 1'b0;
    @(negedge clk);
    check(mem_sel && addr == 12'h500 && !cmd_ready, "R8 held command taken",
          addr, 12'h500);
    @(posedge clk); #1;
    words(2, 1'b0);
    repeat (3) @(posedge clk);
    #1;

    check(exp_q.size() == 0, "R4 all expected items seen", exp_q.size(), 0);
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule